// File: doc/BRIEF.md
# Multi-Batch Shader Issue Scheduler

This block decides which resident pixel batch feeds a quad-wide shader ALU pipeline next. A batch is sixteen pixels, which is four quads. The pipeline works in fixed four-clock issue windows. In each window one batch sends one instruction, one quad per clock. When that instruction is a texture fetch, the four quad requests go to a separate texture unit and the batch is parked. The other resident batches keep the pipeline busy until all four quad results have come back. Texture latency is therefore covered by switching batches between instructions. The pipeline itself never stalls.

The scheduler has a fixed number of batch slots. Each slot holds a valid bit, a program counter and a mask of texture quads still outstanding. New batches enter through a valid/ready allocation port. A batch leaves when it issues its end-of-program instruction. Instruction decode is outside the block: the environment returns the operation kind of the instruction at `iss_pc`. If no batch is ready at a window boundary, the scheduler inserts a four-clock bubble and flags it.

Top module: `multibatch_issue_sched`

## Requirements
- R1: While reset is high and on the clock after it, `iss_valid`, `idle_stall` and `tex_req_valid` are low and `alloc_ready` is high.
- R2: An allocation is taken when `alloc_valid` and `alloc_ready` are both high. It goes into the lowest-numbered free slot with `alloc_pc` as its program counter. `alloc_ready` is low exactly when every slot holds a batch.
- R3: Each issue lasts four consecutive clocks. During those clocks `iss_quad` steps 0,1,2,3 while `iss_slot` and `iss_pc` hold. A window boundary is a rising edge where `iss_quad` is 3. A batch allocated into an empty scheduler starts issuing at the first boundary after its acceptance.
- R4: At each boundary the scheduler picks the first ready slot in circular order, starting from the slot after the one issued most recently.
- R5: `iss_kind` is sampled on the quad-0 clock. It is decoded as 0 = ALU, 1 = TEX, 2 = END. ALU and TEX advance the slot's program counter by one.
- R6: For a TEX issue, `tex_req_valid` is high one clock after each of the four quad clocks. It carries that clock's slot and quad index, and the texture port carries at most one quad per clock.
- R7: After a TEX issue the slot is not issued again until a response has arrived for each of quads 0 to 3. A repeated response for a quad that already returned does not count. Other ready slots keep issuing meanwhile, and the parked slot resumes at the next program counter.
- R8: An END issue frees its slot. The slot can then be allocated again and its new batch issues from the new program counter.
- R9: When no slot is ready at a boundary, `iss_valid` is low and `idle_stall` is high for the whole four-clock window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | New batch offered |
| alloc_pc | input | PC_W | Start program counter of the new batch |
| alloc_ready | output | 1 | A slot is free |
| iss_valid | output | 1 | An instruction is being issued this clock |
| iss_slot | output | log2(NSLOT) | Slot being issued |
| iss_pc | output | PC_W | Program counter of the issued instruction |
| iss_quad | output | log2(QUADS) | Clock index within the window (quad being issued) |
| iss_kind | input | 2 | Decoded kind of the instruction at `iss_pc` |
| tex_req_valid | output | 1 | Quad texture request |
| tex_req_slot | output | log2(NSLOT) | Slot of the request |
| tex_req_quad | output | log2(QUADS) | Quad of the request |
| tex_rsp_valid | input | 1 | Quad texture result returned |
| tex_rsp_slot | input | log2(NSLOT) | Slot of the result |
| tex_rsp_quad | input | log2(QUADS) | Quad of the result |
| idle_stall | output | 1 | Bubble window: no batch was ready |

## Verification
A batch accepted into an idle scheduler shows on `iss_valid` after 4 − q clocks, where q is the `iss_quad` value seen right after acceptance. The bench computes that count from q and samples exactly there, and it also confirms the clock just before is still idle. Texture requests are due one clock after their quad's issue clock, and the bench compares the timestamps it logs on falling edges against that offset. The outcomes of TEX and END are taken at quad 0, so they are due by the next boundary. The bench checks them through the logged order of issued windows, and it waits long enough for several boundaries to pass before it compares against the expected round-robin sequence.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    OP_ALU = 2'd0,
    OP_TEX = 2'd1,
    OP_END = 2'd2
  } op_kind_e;
endpackage

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] grant_idx,
  output logic          grant_any
);
  // circular search beginning one past the most recent winner
  always_comb begin
    grant_idx = '0;
    grant_any = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(last) + k) % N;
      if (!grant_any && req[c]) begin
        grant_any = 1'b1;
        grant_idx = IW'(c);
      end
    end
  end
endmodule

// File: rtl/sched_slot_table.sv
module sched_slot_table
  import sched_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int PC_W   = 8,
  parameter int QUADS  = 4,
  parameter int SLOT_W = 2,
  parameter int QW     = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        alloc_fire,
  input  logic [PC_W-1:0]             alloc_pc,
  input  logic                        upd_en,
  input  logic [SLOT_W-1:0]           upd_slot,
  input  logic [1:0]                  upd_kind,
  input  logic                        rsp_valid,
  input  logic [SLOT_W-1:0]           rsp_slot,
  input  logic [QW-1:0]               rsp_quad,
  output logic [NSLOT-1:0]            ready_vec,
  output logic [NSLOT-1:0][PC_W-1:0]  pc_arr,
  output logic [SLOT_W-1:0]           free_idx,
  output logic                        any_free
);
  logic [NSLOT-1:0] live;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!live[i]) begin
        free_idx = SLOT_W'(i);
        any_free = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [QUADS-1:0] pend;
    logic [PC_W-1:0]  pc_q;
    logic             live_q;
    wire              hit_alloc = alloc_fire && (free_idx == SLOT_W'(g));
    wire              hit_upd   = upd_en && (upd_slot == SLOT_W'(g));
    wire              hit_rsp   = rsp_valid && (rsp_slot == SLOT_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        live_q <= 1'b0;
        pc_q   <= '0;
        pend   <= '0;
      end else begin
        if (hit_rsp) pend[rsp_quad] <= 1'b0;
        if (hit_alloc) begin
          live_q <= 1'b1;
          pc_q   <= alloc_pc;
          pend   <= '0;
        end
        if (hit_upd) begin
          case (op_kind_e'(upd_kind))
            OP_ALU: pc_q <= pc_q + PC_W'(1);
            OP_TEX: begin
              pc_q <= pc_q + PC_W'(1);
              pend <= '1;
            end
            OP_END: live_q <= 1'b0;
            default: pc_q <= pc_q;
          endcase
        end
      end
    end

    assign live[g]      = live_q;
    assign pc_arr[g]    = pc_q;
    assign ready_vec[g] = live_q && (pend == '0);
  end
endmodule

// File: rtl/multibatch_issue_sched.sv
module multibatch_issue_sched
  import sched_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int PC_W  = 8,
  parameter int QUADS = 4,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int QW     = (QUADS > 1) ? $clog2(QUADS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [PC_W-1:0]   alloc_pc,
  output logic              alloc_ready,
  output logic              iss_valid,
  output logic [SLOT_W-1:0] iss_slot,
  output logic [PC_W-1:0]   iss_pc,
  output logic [QW-1:0]     iss_quad,
  input  logic [1:0]        iss_kind,
  output logic              tex_req_valid,
  output logic [SLOT_W-1:0] tex_req_slot,
  output logic [QW-1:0]     tex_req_quad,
  input  logic              tex_rsp_valid,
  input  logic [SLOT_W-1:0] tex_rsp_slot,
  input  logic [QW-1:0]     tex_rsp_quad,
  output logic              idle_stall
);
  logic [QW-1:0]                phase;
  logic [SLOT_W-1:0]            last_slot;
  logic [NSLOT-1:0]             ready_vec;
  logic [NSLOT-1:0][PC_W-1:0]   pc_arr;
  logic [SLOT_W-1:0]            free_idx, grant_idx;
  logic                         any_free, grant_any;

  wire boundary   = (phase == QW'(QUADS - 1));
  wire alloc_fire = alloc_valid && any_free;
  wire first_quad = iss_valid && (phase == '0);

  sched_slot_table #(
    .NSLOT(NSLOT), .PC_W(PC_W), .QUADS(QUADS), .SLOT_W(SLOT_W), .QW(QW)
  ) u_table (
    .clk(clk), .rst(rst),
    .alloc_fire(alloc_fire), .alloc_pc(alloc_pc),
    .upd_en(first_quad), .upd_slot(iss_slot), .upd_kind(iss_kind),
    .rsp_valid(tex_rsp_valid), .rsp_slot(tex_rsp_slot), .rsp_quad(tex_rsp_quad),
    .ready_vec(ready_vec), .pc_arr(pc_arr),
    .free_idx(free_idx), .any_free(any_free)
  );

  sched_rr_pick #(.N(NSLOT), .IW(SLOT_W)) u_pick (
    .req(ready_vec), .last(last_slot),
    .grant_idx(grant_idx), .grant_any(grant_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= QW'(QUADS - 1);
      last_slot  <= SLOT_W'(NSLOT - 1);
      iss_valid  <= 1'b0;
      iss_slot   <= '0;
      iss_pc     <= '0;
      idle_stall <= 1'b0;
    end else begin
      phase <= boundary ? '0 : phase + QW'(1);
      if (boundary) begin
        iss_valid  <= grant_any;
        idle_stall <= !grant_any;
        if (grant_any) begin
          iss_slot  <= grant_idx;
          iss_pc    <= pc_arr[grant_idx];
          last_slot <= grant_idx;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tex_req_valid <= 1'b0;
      tex_req_slot  <= '0;
      tex_req_quad  <= '0;
    end else begin
      tex_req_valid <= iss_valid && (op_kind_e'(iss_kind) == OP_TEX);
      tex_req_slot  <= iss_slot;
      tex_req_quad  <= phase;
    end
  end

  assign iss_quad    = phase;
  assign alloc_ready = any_free;
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int NSLOT = 4,
  parameter int QUADS = 4,
  localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int QW     = (QUADS > 1) ? $clog2(QUADS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              iss_valid,
  input logic [SLOT_W-1:0] iss_slot,
  input logic [QW-1:0]     iss_quad,
  input logic              idle_stall,
  input logic              tex_req_valid,
  input logic [SLOT_W-1:0] tex_req_slot,
  input logic [QW-1:0]     tex_req_quad,
  input logic [NSLOT-1:0]  ready_vec
);
  // R3: a window walks its quads on one slot
  a_r3_quad_walk: assert property (@(posedge clk) disable iff (rst)
    iss_valid && iss_quad != QW'(QUADS - 1) |=>
      iss_valid && iss_slot == $past(iss_slot) && iss_quad == $past(iss_quad) + QW'(1));

  // R7: a window only starts on a slot with nothing outstanding
  a_r7_start_ready: assert property (@(posedge clk) disable iff (rst)
    iss_valid && iss_quad == '0 |-> ready_vec[iss_slot]);

  // R6: each texture request mirrors the previous clock's issue
  a_r6_tex_follows: assert property (@(posedge clk) disable iff (rst)
    tex_req_valid |-> $past(iss_valid) && tex_req_slot == $past(iss_slot)
                      && tex_req_quad == $past(iss_quad));

  // R9: bubble and issue never coincide
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(iss_valid && idle_stall));

  // R9: a bubble lasts until the window ends
  a_r9_bubble_hold: assert property (@(posedge clk) disable iff (rst)
    idle_stall && iss_quad != QW'(QUADS - 1) |=> idle_stall);
endmodule

bind multibatch_issue_sched sched_checker #(.NSLOT(NSLOT), .QUADS(QUADS)) u_chk (
  .clk(clk), .rst(rst),
  .iss_valid(iss_valid), .iss_slot(iss_slot), .iss_quad(iss_quad),
  .idle_stall(idle_stall),
  .tex_req_valid(tex_req_valid), .tex_req_slot(tex_req_slot),
  .tex_req_quad(tex_req_quad),
  .ready_vec(ready_vec)
);

// File: tb/tb_multibatch_issue_sched.sv
module tb_multibatch_issue_sched;
  localparam int NSLOT = 4, PC_W = 8, QUADS = 4, SW = 2, QW = 2, LOGN = 1024;

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_valid = 1'b0;
  logic [PC_W-1:0] alloc_pc = '0;
  logic alloc_ready, iss_valid, tex_req_valid, idle_stall;
  logic [SW-1:0] iss_slot, tex_req_slot;
  logic [PC_W-1:0] iss_pc;
  logic [QW-1:0] iss_quad, tex_req_quad;
  logic [1:0] iss_kind;
  logic tex_rsp_valid = 1'b0;
  logic [SW-1:0] tex_rsp_slot = '0;
  logic [QW-1:0] tex_rsp_quad = '0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_iss = 0, n_tex = 0;
  int log_slot [LOGN];
  int log_pc   [LOGN];
  int log_cyc  [LOGN];
  int tex_slot [LOGN];
  int tex_quad [LOGN];
  int tex_cyc  [LOGN];

  multibatch_issue_sched #(.NSLOT(NSLOT), .PC_W(PC_W), .QUADS(QUADS)) dut (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_pc(alloc_pc), .alloc_ready(alloc_ready),
    .iss_valid(iss_valid), .iss_slot(iss_slot), .iss_pc(iss_pc),
    .iss_quad(iss_quad), .iss_kind(iss_kind),
    .tex_req_valid(tex_req_valid), .tex_req_slot(tex_req_slot),
    .tex_req_quad(tex_req_quad),
    .tex_rsp_valid(tex_rsp_valid), .tex_rsp_slot(tex_rsp_slot),
    .tex_rsp_quad(tex_rsp_quad),
    .idle_stall(idle_stall)
  );

  always #10 clk = ~clk;  // 50 MHz

  // program model: 0x80 is a texture fetch, 0xC0 ends the program
  always_comb begin
    if (iss_pc == 8'h80)      iss_kind = 2'd1;
    else if (iss_pc == 8'hC0) iss_kind = 2'd2;
    else                      iss_kind = 2'd0;
  end

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (iss_valid && iss_quad == 0 && n_iss < LOGN) begin
        log_slot[n_iss] = int'(iss_slot);
        log_pc[n_iss]   = int'(iss_pc);
        log_cyc[n_iss]  = cyc;
        n_iss++;
      end
      if (tex_req_valid && n_tex < LOGN) begin
        tex_slot[n_tex] = int'(tex_req_slot);
        tex_quad[n_tex] = int'(tex_req_quad);
        tex_cyc[n_tex]  = cyc;
        n_tex++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; alloc_valid = 1'b0; tex_rsp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic alloc(input int pc);
    @(negedge clk);
    alloc_valid = 1'b1; alloc_pc = PC_W'(pc);
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic respond(input int slot, input int quad);
    @(negedge clk);
    tex_rsp_valid = 1'b1; tex_rsp_slot = SW'(slot); tex_rsp_quad = QW'(quad);
    @(negedge clk);
    tex_rsp_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!iss_valid && !idle_stall && !tex_req_valid && alloc_ready, "R1 in reset",
        {iss_valid, idle_stall, tex_req_valid, alloc_ready}, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(!iss_valid && !tex_req_valid && alloc_ready, "R1 after reset",
        {iss_valid, tex_req_valid, alloc_ready}, 1);
  endtask

  task automatic t_idle();
    int bad;
    do_reset();
    bad = 0;
    repeat (12) begin
      @(negedge clk);
      if (iss_valid || !idle_stall || tex_req_valid) bad++;
    end
    chk(bad == 0, "R9 empty scheduler bubbles", bad, 0);
  endtask

  task automatic t_first_issue();
    int q;
    do_reset();
    repeat (5) @(negedge clk);
    alloc_valid = 1'b1; alloc_pc = 8'h44;
    @(negedge clk);
    alloc_valid = 1'b0;
    q = int'(iss_quad);
    repeat (3 - q) @(negedge clk);
    chk(!iss_valid, "R3 no issue before boundary", int'(iss_valid), 0);
    @(negedge clk);
    chk(iss_valid && iss_quad == 0, "R3 issue at first boundary", int'(iss_valid), 1);
    chk(iss_slot == 0 && iss_pc == 8'h44, "R2 lowest slot and start pc",
        int'(iss_pc), 'h44);
  endtask

  task automatic t_round_robin();
    int s;
    int exp_s [6] = '{0, 1, 2, 0, 1, 2};
    int exp_p [6] = '{'h10, 'h20, 'h30, 'h11, 'h21, 'h31};
    int bad;
    do_reset();
    s = n_iss;
    alloc('h10); alloc('h20); alloc('h30);
    repeat (40) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 6; i++)
      if (log_slot[s+i] != exp_s[i]) bad++;
    chk(n_iss - s >= 6 && bad == 0, "R4 circular order", bad, 0);
    bad = 0;
    for (int i = 0; i < 6; i++)
      if (log_pc[s+i] != exp_p[i]) bad++;
    chk(bad == 0, "R5 ALU advances pc", bad, 0);
    // R3: one window in detail
    while (!(iss_valid && iss_quad == 0)) @(negedge clk);
    s = int'(iss_slot);
    bad = 0;
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      if (!iss_valid || int'(iss_quad) != k || int'(iss_slot) != s) bad++;
    end
    chk(bad == 0, "R3 quad steps 0..3", bad, 0);
  endtask

  task automatic t_texture();
    int s, t, m, bad, others;
    int exp_s [5] = '{0, 1, 2, 1, 2};
    do_reset();
    s = n_iss; t = n_tex;
    alloc('h80); alloc('h10); alloc('h20);
    repeat (40) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 5; i++)
      if (log_slot[s+i] != exp_s[i]) bad++;
    chk(bad == 0, "R7 parked slot skipped", bad, 0);
    chk(n_tex - t == 4, "R6 four quad requests", n_tex - t, 4);
    bad = 0;
    for (int k = 0; k < 4; k++)
      if (tex_slot[t+k] != 0 || tex_quad[t+k] != k || tex_cyc[t+k] != log_cyc[s] + k + 1)
        bad++;
    chk(bad == 0, "R6 request slot/quad/timing", bad, 0);
    respond(0, 0); respond(0, 1); respond(0, 2); respond(0, 0);
    repeat (16) @(negedge clk);
    bad = 0; others = 0;
    for (int i = s + 1; i < n_iss; i++) begin
      if (log_slot[i] == 0) bad++;
      else others++;
    end
    chk(bad == 0, "R7 held until quad 3 returns", bad, 0);
    chk(others >= 8, "R7 other batches continue", others, 8);
    m = n_iss;
    respond(0, 3);
    repeat (20) @(negedge clk);
    bad = 1;
    for (int i = m; i < n_iss; i++)
      if (bad == 1 && log_slot[i] == 0) bad = (log_pc[i] == 'h81) ? 0 : 2;
    chk(bad == 0, "R7 resumes at next pc", bad, 0);
  endtask

  task automatic t_end_refill();
    int s, e, bad, waited;
    do_reset();
    s = n_iss;
    alloc('hBF); alloc('h10); alloc('h20); alloc('h30);
    chk(!alloc_ready, "R2 full table not ready", int'(alloc_ready), 0);
    waited = 0;
    while (!alloc_ready && waited < 100) begin
      @(negedge clk); waited++;
    end
    chk(alloc_ready, "R8 END frees a slot", int'(alloc_ready), 1);
    e = -1;
    for (int i = s; i < n_iss; i++)
      if (e < 0 && log_slot[i] == 0 && log_pc[i] == 'hC0) e = i;
    chk(e >= 0, "R8 END issued from slot 0", e, 0);
    alloc('h50);
    repeat (40) @(negedge clk);
    bad = 1;
    for (int i = e + 1; i < n_iss; i++)
      if (bad == 1 && log_slot[i] == 0) bad = (log_pc[i] == 'h50) ? 0 : 2;
    chk(bad == 0, "R8 refilled slot runs new batch", bad, 0);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_idle();
    t_first_issue();
    t_round_robin();
    t_texture();
    t_end_refill();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule